// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Loader

This block sits between a host's 16-bit word port and a bank of 12-bit converters. Every channel owns two registers. One is an input register that the host fills. The other is an output register whose value is driven to the converter. The host picks a channel through a 4-bit pointer and then pushes words through one shared data port. When auto-advance is on, the pointer steps forward after every data word and wraps modulo 16. This lets a whole frame be streamed with no pointer rewrites.

A mode bit selects how data reaches the outputs. In pass-through mode, a data word lands in the addressed channel's output register on the same clock edge as its input register. In frame mode, the output registers keep their values until the host writes the update register. That write copies every input register into its output register on one edge. All outputs leave the block as one packed vector, together with a one-cycle strobe that is high in the cycle the new values first appear.

Top module: `dac_frame_loader`

## Requirements
- R1: During and after reset, every input and output word is 000h when `cfg_bipolar` is 0 and 800h when it is 1. The command register and the pointer are zero, so `dig_out` is 0 and status bits 15:4 are 0.
- R2: A write at byte offset 4 loads bits 11:0 of the bus word into the addressed channel. Bits 15:12 are discarded.
- R3: A write at offset 2 sets the pointer from bits 3:0. Status bits 11:8 always show the pointer, which is the channel the next data word will load.
- R4: With command bit 4 set, each data write advances the pointer by one after loading. Channel 15 is followed by channel 0.
- R5: With command bit 4 clear, data writes leave the pointer unchanged, so repeated words go to one channel.
- R6: With command bit 7 clear, a data write changes the addressed output word on the same edge, and `dac_strobe` is high for exactly the cycle in which the new value first shows.
- R7: With command bit 7 set, data writes change no output word and raise no strobe.
- R8: With command bit 7 set and bit 6 clear, a write of any value at offset 6 copies every input word into its output word on one edge and pulses `dac_strobe`.
- R9: A write at offset 6 while bit 6 is set or bit 7 is clear changes no output and raises no strobe.
- R10: A read at offset 0 returns status: bits 3:0 are `dig_in`, bits 7:4 mirror command bits 7:4, bits 11:8 are the pointer, and bits 15:12 are zero. Every other offset reads as zero.
- R11: Command bits 3:0, written at offset 0, drive `dig_out`.
- R12: With 8 channels, data words whose pointer is 8 to 15 change no register and raise no strobe. The pointer still counts modulo 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bipolar | input | 1 | Static: reset code 800h when 1, 000h when 0 |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Byte offset; bits 3:1 select the register |
| bus_wdata | input | 16 | Write word |
| bus_rdata | output | 16 | Read word for the offset on `bus_addr` |
| dig_in | input | 4 | Discrete inputs reported in status |
| dig_out | output | 4 | Discrete outputs from the command register |
| dac_out | output | NCH*12 | Output words, channel c in bits c*12 +: 12 |
| dac_strobe | output | 1 | High in the cycle output words have just changed |

## Verification
Two things happen on the same edge during a data write: the word is loaded into a channel, and the pointer advances. When that channel is 15, the pointer also wraps. The bench steps the pointer across the 15-to-0 boundary in both modes. After each write it compares the loaded channel, every other channel, and status bits 11:8 against an arithmetic model. In the 8-channel instance the same step crosses 7 to 8. Here the bench confirms that the pointer still moves while the upper-channel writes leave every output and the strobe untouched.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
   localparam int PTR_W = 4;
   localparam int BUS_W = 16;
   localparam int CMD_W = 8;
   localparam logic [2:0] WSEL_CTRL = 3'd0;
   localparam logic [2:0] WSEL_PTR  = 3'd1;
   localparam logic [2:0] WSEL_DATA = 3'd2;
   localparam logic [2:0] WSEL_UPD  = 3'd3;
   localparam int CB_STEP = 4;
   localparam int CB_ARM  = 6;
   localparam int CB_HOLD = 7;
endpackage

// File: rtl/dfl_ctrl.sv
module dfl_ctrl
   import dfl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [2:0]       wsel,
   input  logic [7:0]       wlow,
   output logic [CMD_W-1:0] cmd_q,
   output logic [PTR_W-1:0] ptr_q,
   output logic             data_wr,
   output logic             upd_all,
   output logic             hold
);
   assign data_wr = bus_wr && (wsel == WSEL_DATA);
   assign hold    = cmd_q[CB_HOLD];
   assign upd_all = bus_wr && (wsel == WSEL_UPD) && cmd_q[CB_HOLD] && !cmd_q[CB_ARM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         ptr_q <= '0;
      end else begin
         if (bus_wr && wsel == WSEL_CTRL) cmd_q <= wlow;
         if (bus_wr && wsel == WSEL_PTR)
            ptr_q <= wlow[PTR_W-1:0];
         else if (data_wr && cmd_q[CB_STEP])
            ptr_q <= ptr_q + 1'b1;
      end
   end

   assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && cmd_q[CB_STEP] && ptr_q == 4'hF) |=> (ptr_q == 4'h0));
   assert_ptr_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !cmd_q[CB_STEP]) |=> $stable(ptr_q));
endmodule

// File: rtl/dfl_chan.sv
module dfl_chan #(
   parameter int DW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bipolar,
   input  logic          sel,
   input  logic [DW-1:0] wdata,
   input  logic          hold,
   input  logic          upd_all,
   output logic [DW-1:0] out_q,
   output logic          loaded
);
   localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};
   logic [DW-1:0] in_q;
   logic [DW-1:0] rst_val;

   assign rst_val = bipolar ? MID : '0;
   assign loaded  = upd_all || (sel && !hold);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= rst_val;
         out_q <= rst_val;
      end else begin
         if (sel) in_q <= wdata;
         if (upd_all)
            out_q <= in_q;
         else if (sel && !hold)
            out_q <= wdata;
      end
   end

   assert_bulk_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_all |=> (out_q == $past(in_q)));
   assert_hold_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !upd_all) |=> $stable(out_q));
endmodule

// File: rtl/dfl_readback.sv
module dfl_readback
   import dfl_pkg::*;
(
   input  logic [2:0]       wsel,
   input  logic [CMD_W-1:0] cmd_q,
   input  logic [PTR_W-1:0] ptr_q,
   input  logic [3:0]       dig_in,
   output logic [BUS_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (wsel == WSEL_CTRL) rdata = {4'h0, ptr_q, cmd_q[7:4], dig_in};
   end
endmodule

// File: rtl/dac_frame_loader.sv
module dac_frame_loader
   import dfl_pkg::*;
#(
   parameter int NCH = 16,
   parameter int DW  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bipolar,
   input  logic              bus_wr,
   input  logic [3:0]        bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   input  logic [3:0]        dig_in,
   output logic [3:0]        dig_out,
   output logic [NCH*DW-1:0] dac_out,
   output logic              dac_strobe
);
   localparam int MAXCH = 1 << PTR_W;

   generate
      if (NCH != 8 && NCH != 16) begin : g_bad_nch
         $error("NCH must be 8 or 16");
      end
      if (DW < 2 || DW > BUS_W) begin : g_bad_dw
         $error("DW out of range");
      end
   endgenerate

   logic [2:0]       wsel;
   logic [CMD_W-1:0] cmd_q;
   logic [PTR_W-1:0] ptr_q;
   logic             data_wr, upd_all, hold;
   logic [NCH-1:0]   loaded;
   logic             unused_bits;

   assign wsel        = bus_addr[3:1];
   assign unused_bits = ^{bus_addr[0], bus_wdata[15:8]};
   assign dig_out     = cmd_q[3:0];

   dfl_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .wsel(wsel),
      .wlow(bus_wdata[7:0]), .cmd_q(cmd_q), .ptr_q(ptr_q),
      .data_wr(data_wr), .upd_all(upd_all), .hold(hold)
   );

   dfl_readback u_rb (
      .wsel(wsel), .cmd_q(cmd_q), .ptr_q(ptr_q), .dig_in(dig_in), .rdata(bus_rdata)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel;
      assign sel = data_wr && (ptr_q == PTR_W'(c));
      dfl_chan #(.DW(DW)) u_ch (
         .clk(clk), .rst_n(rst_n), .bipolar(cfg_bipolar), .sel(sel),
         .wdata(bus_wdata[DW-1:0]), .hold(hold), .upd_all(upd_all),
         .out_q(dac_out[c*DW +: DW]), .loaded(loaded[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dac_strobe <= 1'b0;
      else        dac_strobe <= |loaded;
   end

   assert_strobe_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dac_strobe |-> $past(bus_wr));
   assert_one_channel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !hold) |-> $countones(loaded) <= 1);
   generate
      if (NCH < MAXCH) begin : g_small
         assert_upper_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (data_wr && ptr_q >= PTR_W'(NCH)) |=> (!dac_strobe && $stable(dac_out)));
      end
   endgenerate
endmodule

// File: tb/dac_frame_loader_test.sv
module dac_frame_loader_test;
   localparam int CLK_NS = 10;
   localparam int DW = 12;

   logic clk = 0;
   logic rst_n = 0;
   logic bus_wr = 0;
   logic [3:0] bus_addr = 0;
   logic [15:0] bus_wdata = 0;
   logic [3:0] dig_in = 4'hA;
   logic [15:0] rd_a, rd_b;
   logic [3:0] dout_a, dout_b;
   logic [16*DW-1:0] out_a;
   logic [8*DW-1:0] out_b;
   logic stb_a, stb_b;

   int errors = 0, checks = 0;
   bit done = 0;
   int m_cmd = 0, m_ptr = 0;
   int m_in[2][16], m_out[2][16];
   bit m_stb[2];
   int nch[2] = '{16, 8};

   always #(CLK_NS/2) clk = ~clk;

   dac_frame_loader #(.NCH(16), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_bipolar(1'b0), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_a),
      .dig_in(dig_in), .dig_out(dout_a), .dac_out(out_a), .dac_strobe(stb_a));

   dac_frame_loader #(.NCH(8), .DW(DW)) uut8 (
      .clk(clk), .rst_n(rst_n), .cfg_bipolar(1'b1), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_b),
      .dig_in(dig_in), .dig_out(dout_b), .dac_out(out_b), .dac_strobe(stb_b));

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      for (int c = 0; c < 16; c++) chk({tag, " out16"}, int'(out_a[c*DW +: DW]), m_out[0][c]);
      for (int c = 0; c < 8; c++)  chk({tag, " out8"}, int'(out_b[c*DW +: DW]), m_out[1][c]);
      chk({tag, " strobe16"}, int'(stb_a), int'(m_stb[0]));
      chk({tag, " strobe8"}, int'(stb_b), int'(m_stb[1]));
      chk({tag, " R10 R3 status"}, int'(rd_a), (m_ptr << 8) | (m_cmd & 'hF0) | int'(dig_in));
      chk({tag, " R10 status8"}, int'(rd_b), (m_ptr << 8) | (m_cmd & 'hF0) | int'(dig_in));
      chk({tag, " R11 dig_out"}, int'(dout_a), m_cmd & 'hF);
   endtask

   task automatic model(int a, int d);
      m_stb[0] = 0; m_stb[1] = 0;
      case (a >> 1)
         0: m_cmd = d & 'hFF;
         1: m_ptr = d & 'hF;
         2: begin
            for (int i = 0; i < 2; i++)
               if (m_ptr < nch[i]) begin
                  m_in[i][m_ptr] = d & 'hFFF;
                  if (!m_cmd[7]) begin
                     m_out[i][m_ptr] = d & 'hFFF;
                     m_stb[i] = 1;
                  end
               end
            if (m_cmd[4]) m_ptr = (m_ptr + 1) % 16;
         end
         3: if (m_cmd[7] && !m_cmd[6])
               for (int i = 0; i < 2; i++) begin
                  for (int c = 0; c < nch[i]; c++) m_out[i][c] = m_in[i][c];
                  m_stb[i] = 1;
               end
         default: ;
      endcase
   endtask

   task automatic wr(int a, int d, string tag);
      @(negedge clk);
      bus_wr = 1; bus_addr = 4'(a); bus_wdata = 16'(d);
      @(negedge clk);
      bus_wr = 0; bus_addr = 0;
      model(a, d);
      #1;
      check_all(tag);
   endtask

   initial begin
      #(CLK_NS * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got %h expected %h", 0, 1);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 16; c++) begin
         m_in[0][c] = 0; m_out[0][c] = 0;
         m_in[1][c] = 'h800; m_out[1][c] = 'h800;
      end
      m_stb[0] = 0; m_stb[1] = 0;
      repeat (3) @(negedge clk);
      #1 check_all("R1 in reset");
      rst_n = 1;
      @(negedge clk); #1 check_all("R1 after reset");
      // R10: sweep all digital input codes
      for (int v = 0; v < 16; v++) begin
         dig_in = 4'(v); #1;
         chk("R10 dig_in", int'(rd_a[3:0]), v);
      end
      // R10: other offsets read zero
      for (int a = 2; a < 16; a += 2) begin
         bus_addr = 4'(a); #1;
         chk("R10 other offset", int'(rd_a), 0);
      end
      bus_addr = 0;
      wr(0, 'hFF05, "R11 cmd");
      wr(0, 'h0000, "R11 cmd clear");
      // R2 R6 R12: pass-through, fixed pointer, every channel
      for (int c = 0; c < 16; c++) begin
         wr(2, 'hFFF0 | c, "R3 ptr");
         wr(4, 'hF000 | ((c * 'h131) ^ 'h5A5), "R2 R6 R12 direct");
      end
      // R5: repeated words stay on one channel
      wr(2, 3, "R3 ptr");
      for (int k = 0; k < 3; k++) wr(4, 'h100 + k, "R5 same chan");
      // R4: auto-advance, cross 15->0 and 7->8
      wr(0, 'h10, "R4 cmd");
      wr(2, 5, "R3 ptr");
      for (int k = 0; k < 20; k++) wr(4, 'hA000 | (k * 'h97), "R4 R12 advance wrap");
      // R7 R8: frame mode
      wr(0, 'h90, "R7 cmd");
      wr(2, 0, "R3 ptr");
      for (int k = 0; k < 16; k++) wr(4, 'h3C3 ^ (k * 'h111), "R7 hold");
      wr(6, 'h1234, "R8 update");
      wr(6, 'h0, "R8 update again");
      // R9: update inhibited with bit 6, and in pass-through mode
      wr(0, 'hD0, "R9 cmd");
      for (int k = 0; k < 18; k++) wr(4, 'h777 + k * 3, "R9 R7 load");
      wr(6, 'hFFFF, "R9 armed update ignored");
      wr(0, 'h00, "R9 cmd");
      wr(6, 'h0, "R9 pass-through update ignored");
      wr(0, 'h80, "R8 cmd");
      wr(6, 'h0, "R8 late update");
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule